// File: doc/BRIEF.md
# DMA Graceful Stop and Poll Control

This block holds the control side of a multi-ring Ethernet DMA engine: the stop-request bits and the poll-wait bit of the DMA control register, and the per-ring halt flags of the transmit and receive status registers. When software asks for a graceful stop, the block waits until the frame in flight on that side has finished and then pulses a stop-complete event. If no frame is in flight, the event follows at once. A periodic poll timer nudges transmit ring 0 to look for new descriptors while software has not asked it to wait.

Writes to the two status registers clear halt flags and turn into per-ring restart pulses for the descriptor engines. A transmit restart is issued for every bit written as 1. A receive restart is issued only for rings whose halt flag was already clear. The ring engines raise halt flags through per-ring set inputs. Several rings can be restarted in the same cycle.

Top module: `dma_stop_poll_ctrl`

## Requirements
- R1: A control write with bit 3 (receive stop) set while `rx_frame_busy` is low gives one `rx_stop_done` pulse in the cycle after the write.
- R2: A receive stop requested while `rx_frame_busy` is high is held back, with no event, for as long as busy stays high. `rx_stop_done` pulses in the cycle after the first cycle in which busy is low.
- R3: Bit 4 (transmit stop) behaves like R1 and R2, using `tx_frame_busy` and `tx_stop_done`.
- R4: A control write with bit 6 (wait-for-poll) clear reloads the poll timer. Expiries then follow every POLL_CYCLES = CLK_HZ / POLL_HZ cycles, and the first restart pulse appears POLL_CYCLES cycles after the pulse-producing cycle of the write.
- R5: At expiry, if the stored wait bit is clear, the timer re-arms. `tx_restart[0]` pulses unless the stored transmit stop bit is set.
- R6: At expiry, if the stored wait bit is set, the timer stops and no poll pulse is produced. A control write with the wait bit set does not reload the timer.
- R7: In a transmit status write, data bit (31 - i) set gives a `tx_restart[i]` pulse in the next cycle, whatever the state of the halt flag, and clears `tx_halt[i]`.
- R8: In a receive status write, data bit (23 - i) set clears `rx_halt[i]`. It gives an `rx_restart[i]` pulse only if `rx_halt[i]` was 0 before the write.
- R9: A set input raises its halt flag in the next cycle. If a set and a clear of the same flag fall in the same cycle, the set wins.
- R10: Restart and stop-complete outputs are single-cycle pulses. A poll restart and a status-write restart in the same cycle combine, so several bits of `tx_restart` can be high together.
- R11: After reset, all halt flags and pulses are 0, the stored control bits are 0 and the poll timer is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Write strobe for the DMA control register |
| ctrl_wdata | input | 32 | Control write data (bit 3 rx stop, bit 4 tx stop, bit 6 wait-for-poll) |
| tx_stat_wr | input | 1 | Write strobe for the transmit status register |
| rx_stat_wr | input | 1 | Write strobe for the receive status register |
| stat_wdata | input | 32 | Status write data, shared by both status registers |
| tx_frame_busy | input | 1 | A transmit frame is in progress |
| rx_frame_busy | input | 1 | A receive frame is in progress |
| tx_halt_set | input | NUM_RINGS | Per-ring transmit halt raise |
| rx_halt_set | input | NUM_RINGS | Per-ring receive halt raise |
| tx_stop_done | output | 1 | Transmit graceful stop complete pulse |
| rx_stop_done | output | 1 | Receive graceful stop complete pulse |
| tx_restart | output | NUM_RINGS | Per-ring transmit restart pulses |
| rx_restart | output | NUM_RINGS | Per-ring receive restart pulses |
| tx_halt | output | NUM_RINGS | Transmit halt flags, ring i at bit i |
| rx_halt | output | NUM_RINGS | Receive halt flags, ring i at bit i |

## Verification
A poll expiry and a transmit status write can land in the same cycle, and both drive `tx_restart`. The bench counts cycles from the control write that started the timer. It places a status write for ring 3 so that it is sampled on the very edge at which the timer expires. The scoreboard then expects 8'h09 on `tx_restart` in exactly that cycle and nothing in the cycles either side. A second overlap, a halt set and a halt clear of the same receive ring, is judged by the halt flag and the restart pulse that follow.

// File: rtl/gsp_pkg.sv
package gsp_pkg;
    localparam int CTRL_RX_STOP_BIT   = 3;
    localparam int CTRL_TX_STOP_BIT   = 4;
    localparam int CTRL_WAIT_POLL_BIT = 6;
    localparam int TX_HALT_TOP        = 31;
    localparam int RX_HALT_TOP        = 23;

    typedef struct packed {
        logic rx_stop;
        logic tx_stop;
        logic wait_poll;
    } ctrl_bits_t;

    typedef enum logic {
        POLL_IDLE = 1'b0,
        POLL_RUN  = 1'b1
    } poll_state_e;

    function automatic ctrl_bits_t decode_ctrl(input logic rx_b, input logic tx_b,
                                               input logic wt_b);
        ctrl_bits_t c;
        c.rx_stop   = rx_b;
        c.tx_stop   = tx_b;
        c.wait_poll = wt_b;
        return c;
    endfunction

    function automatic int poll_period(input int clk_hz, input int poll_hz);
        return clk_hz / poll_hz;
    endfunction
endpackage

// File: rtl/gstop_unit.sv
module gstop_unit (
    input  logic clk,
    input  logic rst,
    input  logic req,
    input  logic busy,
    output logic done
);
    logic pend_q;
    logic done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= (req || pend_q) && !busy;
            pend_q <= busy && (req || pend_q);
        end
    end

    assign done = done_q;

    AST_STOP_IMMEDIATE: assert property (@(posedge clk) disable iff (rst)
        req && !busy |=> done);  // R1, R3
    AST_STOP_DEFERRED: assert property (@(posedge clk) disable iff (rst)
        busy |=> !done);  // R2, R3
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int CYCLES = 1000000
) (
    input  logic clk,
    input  logic rst,
    input  logic ctrl_wr,
    input  logic wait_new,
    input  logic wait_q,
    input  logic stop_tx_q,
    output logic poll_req
);
    import gsp_pkg::*;

    localparam int CW = (CYCLES > 2) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] RELOAD = CW'(CYCLES - 1);

    poll_state_e state_q;
    logic [CW-1:0] cnt_q;
    logic req_q;
    logic expire;
    logic reload;

    assign expire = (state_q == POLL_RUN) && (cnt_q == '0);
    assign reload = (ctrl_wr && !wait_new) || (expire && !wait_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= POLL_IDLE;
            cnt_q   <= '0;
            req_q   <= 1'b0;
        end else begin
            req_q <= expire && !wait_q && !stop_tx_q;
            if (reload) begin
                cnt_q   <= RELOAD;
                state_q <= POLL_RUN;
            end else if (expire) begin
                state_q <= POLL_IDLE;
            end else if (state_q == POLL_RUN) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign poll_req = req_q;

    AST_POLL_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state_q == POLL_IDLE) |=> !poll_req);  // R6
    AST_POLL_STOP_GATES: assert property (@(posedge clk) disable iff (rst)
        stop_tx_q |=> !poll_req);  // R5
    AST_POLL_WAIT_GATES: assert property (@(posedge clk) disable iff (rst)
        wait_q |=> !poll_req);  // R6
endmodule

// File: rtl/halt_status.sv
module halt_status #(
    parameter int NR            = 8,
    parameter bit ONLY_IF_CLEAR = 1'b0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [NR-1:0] field,
    input  logic [NR-1:0] set,
    output logic [NR-1:0] halt,
    output logic [NR-1:0] restart
);
    logic [NR-1:0] hit;
    logic [NR-1:0] grant;
    logic [NR-1:0] halt_q;
    logic [NR-1:0] restart_q;

    for (genvar i = 0; i < NR; i++) begin : g_ring
        assign hit[i] = wr && field[NR-1-i];
        if (ONLY_IF_CLEAR) begin : g_cond
            assign grant[i] = hit[i] && !halt_q[i];
            AST_RESTART_BLOCKED: assert property (@(posedge clk) disable iff (rst)
                hit[i] && halt_q[i] |=> !restart_q[i]);  // R8
        end else begin : g_uncond
            assign grant[i] = hit[i];
            AST_RESTART_ALWAYS: assert property (@(posedge clk) disable iff (rst)
                hit[i] |=> restart_q[i]);  // R7
        end
        AST_HALT_CLEARED: assert property (@(posedge clk) disable iff (rst)
            hit[i] && !set[i] |=> !halt_q[i]);  // R7, R8
        AST_HALT_SET_WINS: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> halt_q[i]);  // R9
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            halt_q    <= '0;
            restart_q <= '0;
        end else begin
            halt_q    <= (halt_q & ~hit) | set;
            restart_q <= grant;
        end
    end

    assign halt    = halt_q;
    assign restart = restart_q;
endmodule

// File: rtl/dma_stop_poll_ctrl.sv
module dma_stop_poll_ctrl #(
    parameter int NUM_RINGS = 8,
    parameter int CLK_HZ    = 100000000,
    parameter int POLL_HZ   = 100
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_wr,
    input  logic [31:0]          ctrl_wdata,
    input  logic                 tx_stat_wr,
    input  logic                 rx_stat_wr,
    input  logic [31:0]          stat_wdata,
    input  logic                 tx_frame_busy,
    input  logic                 rx_frame_busy,
    input  logic [NUM_RINGS-1:0] tx_halt_set,
    input  logic [NUM_RINGS-1:0] rx_halt_set,
    output logic                 tx_stop_done,
    output logic                 rx_stop_done,
    output logic [NUM_RINGS-1:0] tx_restart,
    output logic [NUM_RINGS-1:0] rx_restart,
    output logic [NUM_RINGS-1:0] tx_halt,
    output logic [NUM_RINGS-1:0] rx_halt
);
    import gsp_pkg::*;

    localparam int POLL_CYCLES = poll_period(CLK_HZ, POLL_HZ);

    ctrl_bits_t wr_bits;
    ctrl_bits_t ctrl_q;
    logic poll_req;
    logic [NUM_RINGS-1:0] tx_stat_restart;
    logic unused_wdata;

    assign unused_wdata = ^{ctrl_wdata, stat_wdata};

    assign wr_bits = decode_ctrl(ctrl_wdata[CTRL_RX_STOP_BIT],
                                 ctrl_wdata[CTRL_TX_STOP_BIT],
                                 ctrl_wdata[CTRL_WAIT_POLL_BIT]);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wr_bits;
        end
    end

    gstop_unit u_rx_stop (
        .clk  (clk),
        .rst  (rst),
        .req  (ctrl_wr && wr_bits.rx_stop),
        .busy (rx_frame_busy),
        .done (rx_stop_done)
    );

    gstop_unit u_tx_stop (
        .clk  (clk),
        .rst  (rst),
        .req  (ctrl_wr && wr_bits.tx_stop),
        .busy (tx_frame_busy),
        .done (tx_stop_done)
    );

    poll_timer #(.CYCLES(POLL_CYCLES)) u_poll (
        .clk       (clk),
        .rst       (rst),
        .ctrl_wr   (ctrl_wr),
        .wait_new  (wr_bits.wait_poll),
        .wait_q    (ctrl_q.wait_poll),
        .stop_tx_q (ctrl_q.tx_stop),
        .poll_req  (poll_req)
    );

    halt_status #(.NR(NUM_RINGS), .ONLY_IF_CLEAR(1'b0)) u_tx_halt (
        .clk     (clk),
        .rst     (rst),
        .wr      (tx_stat_wr),
        .field   (stat_wdata[TX_HALT_TOP -: NUM_RINGS]),
        .set     (tx_halt_set),
        .halt    (tx_halt),
        .restart (tx_stat_restart)
    );

    halt_status #(.NR(NUM_RINGS), .ONLY_IF_CLEAR(1'b1)) u_rx_halt (
        .clk     (clk),
        .rst     (rst),
        .wr      (rx_stat_wr),
        .field   (stat_wdata[RX_HALT_TOP -: NUM_RINGS]),
        .set     (rx_halt_set),
        .halt    (rx_halt),
        .restart (rx_restart)
    );

    assign tx_restart = tx_stat_restart | {{(NUM_RINGS-1){1'b0}}, poll_req};

    AST_POLL_MERGED: assert property (@(posedge clk) disable iff (rst)
        poll_req |-> tx_restart[0]);  // R10
    AST_CTRL_WAIT_NO_RELOAD: assert property (@(posedge clk) disable iff (rst)
        ctrl_wr && wr_bits.wait_poll |=> ctrl_q.wait_poll);  // R6
endmodule

// File: tb/dma_stop_poll_ctrl_bench.sv
`timescale 1ns/1ps
module dma_stop_poll_ctrl_bench;
    localparam int NR = 8;
    localparam int P  = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ctrl_wr = 1'b0;
    logic [31:0] ctrl_wdata = '0;
    logic tx_stat_wr = 1'b0;
    logic rx_stat_wr = 1'b0;
    logic [31:0] stat_wdata = '0;
    logic tx_frame_busy = 1'b0;
    logic rx_frame_busy = 1'b0;
    logic [NR-1:0] tx_halt_set = '0;
    logic [NR-1:0] rx_halt_set = '0;
    logic tx_stop_done, rx_stop_done;
    logic [NR-1:0] tx_restart, rx_restart, tx_halt, rx_halt;

    int cyc = 0;
    int checked = 0;
    int failed = 0;
    bit finished = 0;

    typedef struct {
        logic [NR-1:0] tx;
        logic [NR-1:0] rx;
        logic txd;
        logic rxd;
        string tag;
    } exp_t;
    exp_t sb[int];

    localparam logic [31:0] WAITB = 32'h40;
    localparam logic [31:0] RXSTP = 32'h08;
    localparam logic [31:0] TXSTP = 32'h10;

    dma_stop_poll_ctrl #(.NUM_RINGS(NR), .CLK_HZ(2000), .POLL_HZ(100)) u_dma_stop_poll_ctrl (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .tx_stat_wr(tx_stat_wr), .rx_stat_wr(rx_stat_wr), .stat_wdata(stat_wdata),
        .tx_frame_busy(tx_frame_busy), .rx_frame_busy(rx_frame_busy),
        .tx_halt_set(tx_halt_set), .rx_halt_set(rx_halt_set),
        .tx_stop_done(tx_stop_done), .rx_stop_done(rx_stop_done),
        .tx_restart(tx_restart), .rx_restart(rx_restart),
        .tx_halt(tx_halt), .rx_halt(rx_halt)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic void push(int at, logic [NR-1:0] tx, logic [NR-1:0] rx,
                                 logic txd, logic rxd, string tag);
        if (!sb.exists(at)) begin
            exp_t e;
            e.tx = '0; e.rx = '0; e.txd = 1'b0; e.rxd = 1'b0; e.tag = tag;
            sb[at] = e;
        end
        sb[at].tx  = sb[at].tx | tx;
        sb[at].rx  = sb[at].rx | rx;
        sb[at].txd = sb[at].txd | txd;
        sb[at].rxd = sb[at].rxd | rxd;
    endfunction

    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (sb.exists(cyc)) begin
                checked++;
                if (tx_restart !== sb[cyc].tx || rx_restart !== sb[cyc].rx ||
                    tx_stop_done !== sb[cyc].txd || rx_stop_done !== sb[cyc].rxd) begin
                    failed++;
                    $display("FAIL %s cyc %0d: got tx=%h rx=%h txd=%b rxd=%b exp tx=%h rx=%h txd=%b rxd=%b",
                             sb[cyc].tag, cyc, tx_restart, rx_restart, tx_stop_done, rx_stop_done,
                             sb[cyc].tx, sb[cyc].rx, sb[cyc].txd, sb[cyc].rxd);
                end
                sb.delete(cyc);
            end else if (tx_restart !== '0 || rx_restart !== '0 ||
                         tx_stop_done !== 1'b0 || rx_stop_done !== 1'b0) begin
                checked++;
                failed++;
                $display("FAIL R10 cyc %0d: unexpected pulse tx=%h rx=%h txd=%b rxd=%b exp all 0",
                         cyc, tx_restart, rx_restart, tx_stop_done, rx_stop_done);
            end
        end
    end

    task automatic check_lvl(string tag, logic [NR-1:0] got, logic [NR-1:0] exp);
        checked++;
        if (got !== exp) begin
            failed++;
            $display("FAIL %s: got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    task automatic wait_until(int t);
        while (cyc < t) step();
    endtask

    task automatic wr_ctrl(logic [31:0] d);
        ctrl_wr = 1'b1; ctrl_wdata = d;
        step();
        ctrl_wr = 1'b0; ctrl_wdata = '0;
    endtask

    task automatic wr_tstat(logic [31:0] d);
        tx_stat_wr = 1'b1; stat_wdata = d;
        step();
        tx_stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic wr_rstat(logic [31:0] d);
        rx_stat_wr = 1'b1; stat_wdata = d;
        step();
        rx_stat_wr = 1'b0; stat_wdata = '0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checked, failed);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checked++;
            failed++;
            $display("FAIL watchdog: got timeout exp completion");
            summary();
        end
    end

    initial begin
        int c, g;
        repeat (3) @(posedge clk);
        #1;
        // R11: reset state
        check_lvl("R11 tx_halt", tx_halt, '0);
        check_lvl("R11 rx_halt", rx_halt, '0);
        check_lvl("R11 pulses", {tx_restart | rx_restart}, '0);
        rst = 1'b0;
        step();

        // R1: receive stop with no frame in flight
        c = cyc; wr_ctrl(WAITB | RXSTP);
        push(c + 1, '0, '0, 1'b0, 1'b1, "R1");
        step();

        // R2: receive stop deferred until busy drops
        rx_frame_busy = 1'b1;
        wr_ctrl(WAITB | RXSTP);
        repeat (4) step();
        c = cyc; rx_frame_busy = 1'b0;
        push(c + 1, '0, '0, 1'b0, 1'b1, "R2");
        step(); step();

        // R3: transmit stop, immediate then deferred
        c = cyc; wr_ctrl(WAITB | TXSTP);
        push(c + 1, '0, '0, 1'b1, 1'b0, "R3 now");
        tx_frame_busy = 1'b1;
        wr_ctrl(WAITB | TXSTP);
        repeat (5) step();
        c = cyc; tx_frame_busy = 1'b0;
        push(c + 1, '0, '0, 1'b1, 1'b0, "R3 deferred");
        step();
        wr_ctrl(WAITB);
        step();

        // R9: set raises halt flags
        tx_halt_set = 8'hFF; step(); tx_halt_set = '0;
        check_lvl("R9 tx set", tx_halt, 8'hFF);

        // R7: transmit status write, rings 0 and 3
        c = cyc; wr_tstat(32'h9000_0000);
        push(c + 1, 8'h09, '0, 1'b0, 1'b0, "R7 rings0,3");
        check_lvl("R7 tx cleared", tx_halt, 8'hF6);
        c = cyc; wr_tstat(32'h8000_0000);
        push(c + 1, 8'h01, '0, 1'b0, 1'b0, "R7 already clear");
        check_lvl("R7 tx unchanged", tx_halt, 8'hF6);

        // R8: receive status write, ring 0 halted, ring 5 not
        rx_halt_set = 8'h0F; step(); rx_halt_set = '0;
        check_lvl("R9 rx set", rx_halt, 8'h0F);
        c = cyc; wr_rstat(32'h0084_0000);
        push(c + 1, '0, 8'h20, 1'b0, 1'b0, "R8 only ring5");
        check_lvl("R8 rx cleared", rx_halt, 8'h0E);

        // R9: set and clear of ring 4 in one cycle
        c = cyc; rx_halt_set = 8'h10;
        wr_rstat(32'h0008_0000);
        rx_halt_set = '0;
        push(c + 1, '0, 8'h10, 1'b0, 1'b0, "R9 set vs clear");
        check_lvl("R9 set wins", rx_halt, 8'h1E);
        step();

        // R4/R5/R10: poll timer with wait clear
        c = cyc; wr_ctrl(32'h0);
        push(c + 1 + P, 8'h01, '0, 1'b0, 1'b0, "R4 first poll");
        push(c + 1 + 2 * P, 8'h01, '0, 1'b0, 1'b0, "R5 re-armed poll");
        wait_until(c + 2 * P);
        wr_tstat(32'h1000_0000);
        push(c + 1 + 2 * P, 8'h08, '0, 1'b0, 1'b0, "R10 merged");

        // R5: transmit stop set blocks poll pulse, reload by write
        g = cyc; wr_ctrl(TXSTP);
        push(g + 1, '0, '0, 1'b1, 1'b0, "R3 stop with poll");
        wait_until(g + 25);

        // R6: wait set, timer stops without pulses
        wr_ctrl(WAITB);
        wait_until(g + 120);
        check_lvl("R6 no pending", {tx_restart | rx_restart}, '0);

        if (sb.size() != 0) begin
            foreach (sb[k]) begin
                checked++;
                failed++;
                $display("FAIL %s cyc %0d: got missed exp pulse", sb[k].tag, k);
            end
        end
        finished = 1;
        summary();
    end
endmodule